// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block is the command front end through which a CPU erases, writes and locks its own program flash. Software writes an 8-bit control register to arm a single command. The command runs only if a store strobe follows within four clock cycles. A load strobe within three cycles returns special data: a signature byte, the lock bits or the fuse bits. If no qualifying strobe arrives, the armed bits clear by themselves.

Page erase and page write go to a backend modelled as a counter. The counter holds the operation busy for a fixed number of cycles and then pulses done. The block also tracks a busy flag for the read-while-write (RWW) flash section and the fill state of the temporary page buffer. It raises a ready interrupt request whenever no operation is armed or running.

Control register bits, MSB to LSB: [7] interrupt enable, [6] RWW busy (read-only), [5] signature read, [4] RWW re-enable, [3] lock set, [2] page write, [1] page erase, [0] enable.

Top module: `fspm_ctrl`

## Requirements
- R1: After reset, `reg_rdata` is 0x00, `lock_bits` is 0xFF, and `rww_busy`, `prog_busy`, `prog_done`, `buf_full`, `buf_drop` and `irq` are all 0.
- R2: A register write with bit 0 set, while bit 0 is clear, arms the written command bits. A store strobe sampled 1 to 4 clock edges after that write runs the command. With no such strobe, bit 0 and the command bits read 0 from the fourth edge after the write onward, and a later store strobe does nothing.
- R3: A load strobe held during the first three cycles after arming drives `ld_special`=1. The data is then `sig_data` for signature read (bit 5). For lock set (bit 3) it is `lock_bits` when `zptr[0]`=0 and `fuse_data` when `zptr[0]`=1. In every other case `ld_special`=0 and `ld_data`=0x00.
- R4: A store strobe inside the window of an armed signature read changes nothing. The bits stay set until the window expires.
- R5: A store on an armed page erase or page write starts the backend with `prog_page` = `zptr[15:7]` and `prog_write` = 1 for write and 0 for erase. `prog_busy` and the register bits stay set for PROG_CYCLES cycles. In the next cycle, bits 0–2 read 0 and `prog_done` is high for one cycle.
- R6: An erase or write to a page below RWW_PAGE_LIMIT sets `rww_busy` (also register bit 6). An operation on a higher page leaves it unchanged.
- R7: `rww_busy` clears on a store after arming RWW re-enable (0x11). It also clears on a store after arming the enable bit alone (0x01), which is a page-buffer load.
- R8: While bit 0 is set, an arming write is ignored apart from bit 7. This includes RWW re-enable during an erase or write.
- R9: Writing bit 4 while bit 0 is clear and the page buffer holds data empties the buffer (`buf_full`=0). `buf_drop` pulses for exactly one cycle.
- R10: A page-buffer load sets `buf_full`. Completion of a page write clears it.
- R11: A store on an armed lock set loads `lock_bits` with `lock_bits & r0_data` and clears bit 0 and bit 3.
- R12: `irq` equals bit 7 AND `gie` AND NOT bit 0.
- R13: When several command bits are armed together, the store runs only the first of erase, write, lock set, RWW re-enable, signature read.
- R14: Bit 7 takes the written value on every register write. Bit 6 ignores the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| gie | input | 1 | CPU global interrupt enable |
| st_strobe | input | 1 | Store (program) strobe |
| ld_strobe | input | 1 | Load strobe |
| zptr | input | 16 | Byte address pointer |
| r0_data | input | 8 | Data operand for lock set |
| sig_data | input | 8 | Signature byte source |
| fuse_data | input | 8 | Fuse byte source |
| ld_special | output | 1 | Load returns special data |
| ld_data | output | 8 | Special load data |
| rww_busy | output | 1 | RWW section busy, reads blocked |
| prog_busy | output | 1 | Backend erase/write running |
| prog_write | output | 1 | Running operation is a write |
| prog_page | output | 9 | Page address of the running operation |
| prog_done | output | 1 | One-cycle completion pulse |
| lock_bits | output | 8 | Current lock bits |
| buf_full | output | 1 | Temporary page buffer holds data |
| buf_drop | output | 1 | Buffer contents were discarded |
| irq | output | 1 | Ready interrupt request |

## Verification
The assertions assume three things about the inputs. Strobes are single-cycle pulses. A store and a load never arrive together. Software never writes the register in the same cycle as a strobe. Every test task keeps to these rules: it raises one strobe for exactly one cycle and only between register writes. Under these conditions, an arming write always meets a closed window, and an erase or write can only start while the backend is idle.

// File: rtl/fspm_pkg.sv
// Shared definitions for the flash self-programming controller.
// Assumes: control register bit positions are fixed by software.
package fspm_pkg;
    localparam int CB_EN    = 0;
    localparam int CB_ERASE = 1;
    localparam int CB_WRITE = 2;
    localparam int CB_LOCK  = 3;
    localparam int CB_RWWRE = 4;
    localparam int CB_SIG   = 5;
    localparam int CB_BUSY  = 6;
    localparam int CB_IE    = 7;

    typedef enum logic [2:0] {
        OP_NONE, OP_FILL, OP_ERASE, OP_WRITE, OP_LOCK, OP_RWWRE, OP_SIG
    } op_e;

    // Priority decode of armed command bits {sig, rwwre, lock, write, erase}.
    function automatic op_e pick_op(input logic [4:0] c);
        if (c[0]) return OP_ERASE;
        if (c[1]) return OP_WRITE;
        if (c[2]) return OP_LOCK;
        if (c[3]) return OP_RWWRE;
        if (c[4]) return OP_SIG;
        return OP_FILL;
    endfunction
endpackage

// File: rtl/fspm_window.sv
// Arming window counter. Opens for STORE_WIN edges after an arming write.
// The load window covers the first LOAD_WIN cycles of it.
// Assumes: arm never coincides with an open window.
module fspm_window #(
    parameter int STORE_WIN = 4,
    parameter int LOAD_WIN  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic close,
    output logic st_open,
    output logic ld_open,
    output logic expire
);
    localparam int CW       = $clog2(STORE_WIN + 1);
    localparam int LOAD_MIN = STORE_WIN - LOAD_WIN + 1;

    logic [CW-1:0] win_q;

    // Load, close or count down the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                win_q <= '0;
        else if (arm)              win_q <= CW'(STORE_WIN);
        else if (close)            win_q <= '0;
        else if (win_q != '0)      win_q <= win_q - 1'b1;
    end

    assign st_open = (win_q != '0);
    assign ld_open = (win_q >= CW'(LOAD_MIN));
    assign expire  = (win_q == CW'(1)) && !close;

    a_r2_win_range: assert property (@(posedge clk) disable iff (!rst_n)
        win_q <= CW'(STORE_WIN));
    a_r8_arm_closed: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !st_open);
    a_r2_expire_shuts: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !st_open);
endmodule

// File: rtl/fspm_prog_timer.sv
// Erase/write backend model: stays busy PROG_CYCLES cycles after start,
// then pulses done for one cycle.
// Assumes: start only while idle; PROG_CYCLES >= 2.
module fspm_prog_timer #(
    parameter int PROG_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic finish,
    output logic done
);
    localparam int TW = $clog2(PROG_CYCLES + 1);

    logic [TW-1:0] cnt_q;
    logic          done_q;

    // Down-count the programming time.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= TW'(PROG_CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // Register the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= finish;
    end

    assign busy   = (cnt_q != '0);
    assign finish = (cnt_q == TW'(1));
    assign done   = done_q;

    a_r8_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/fspm_rww.sv
// Tracks the RWW-section busy flag and the temporary page buffer state.
// Assumes: set_busy and clr_busy are never requested together.
module fspm_rww (
    input  logic clk,
    input  logic rst_n,
    input  logic set_busy,
    input  logic clr_busy,
    input  logic fill,
    input  logic wr_done,
    input  logic abort,
    output logic rww_busy,
    output logic buf_full,
    output logic buf_drop
);
    logic busy_q, full_q, drop_q;

    // RWW busy flag: set by erase/write in the section, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (set_busy) busy_q <= 1'b1;
        else if (clr_busy) busy_q <= 1'b0;
    end

    // Buffer fill state and discard pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            drop_q <= 1'b0;
        end else begin
            drop_q <= abort;
            if (fill)                  full_q <= 1'b1;
            else if (wr_done || abort) full_q <= 1'b0;
        end
    end

    assign rww_busy = busy_q;
    assign buf_full = full_q;
    assign buf_drop = drop_q;

    a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        set_busy |=> rww_busy);
    a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_busy && !set_busy) |=> !rww_busy);
    a_r9_drop_empties: assert property (@(posedge clk) disable iff (!rst_n)
        buf_drop |-> !buf_full);
endmodule

// File: rtl/fspm_ctrl.sv
// Flash self-programming command controller top.
// Holds the control register, decodes the armed command on a store strobe,
// muxes special load data, and drives the ready interrupt.
// Assumes: single-cycle strobes, no store and load together, and no
// register write in the same cycle as a strobe.
module fspm_ctrl #(
    parameter int ZW             = 16,
    parameter int PG_OFS         = 7,
    parameter int RWW_PAGE_LIMIT = 448,
    parameter int PROG_CYCLES    = 16,
    parameter int STORE_WIN      = 4,
    parameter int LOAD_WIN       = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 gie,
    input  logic                 st_strobe,
    input  logic                 ld_strobe,
    input  logic [ZW-1:0]        zptr,
    input  logic [7:0]           r0_data,
    input  logic [7:0]           sig_data,
    input  logic [7:0]           fuse_data,
    output logic                 ld_special,
    output logic [7:0]           ld_data,
    output logic                 rww_busy,
    output logic                 prog_busy,
    output logic                 prog_write,
    output logic [ZW-PG_OFS-1:0] prog_page,
    output logic                 prog_done,
    output logic [7:0]           lock_bits,
    output logic                 buf_full,
    output logic                 buf_drop,
    output logic                 irq
);
    import fspm_pkg::*;

    localparam int PG_W = ZW - PG_OFS;
    localparam logic [PG_W-1:0] RWW_LIM = PG_W'(RWW_PAGE_LIMIT);

    logic       ie_q, en_q;
    logic [4:0] cmd_q;          // {sig, rwwre, lock, write, erase}
    logic [7:0] lock_q;
    logic       wr_q;
    logic [PG_W-1:0] page_q;

    logic st_open, ld_open, expire;
    logic store_hit, close, imm_done, start, finish;
    logic set_busy, clr_busy, abort, arm;
    logic [PG_W-1:0] page;
    op_e  op;

    assign arm       = reg_we && reg_wdata[CB_EN] && !en_q;
    assign store_hit = st_strobe && st_open;
    assign op        = store_hit ? pick_op(cmd_q) : OP_NONE;
    assign close     = store_hit && (op != OP_SIG);
    assign imm_done  = (op == OP_FILL) || (op == OP_LOCK) || (op == OP_RWWRE);
    assign start     = (op == OP_ERASE) || (op == OP_WRITE);
    assign page      = zptr[ZW-1:PG_OFS];
    assign set_busy  = start && (page < RWW_LIM);
    assign clr_busy  = (op == OP_RWWRE) || (op == OP_FILL);
    assign abort     = reg_we && reg_wdata[CB_RWWRE] && !en_q && buf_full;

    fspm_window #(.STORE_WIN(STORE_WIN), .LOAD_WIN(LOAD_WIN)) u_win (
        .clk(clk), .rst_n(rst_n), .arm(arm), .close(close),
        .st_open(st_open), .ld_open(ld_open), .expire(expire)
    );

    fspm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(prog_busy), .finish(finish), .done(prog_done)
    );

    fspm_rww u_rww (
        .clk(clk), .rst_n(rst_n), .set_busy(set_busy), .clr_busy(clr_busy),
        .fill(op == OP_FILL), .wr_done(finish && wr_q), .abort(abort),
        .rww_busy(rww_busy), .buf_full(buf_full), .buf_drop(buf_drop)
    );

    // Control register: arm, then clear on expiry, instant commands or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            en_q  <= 1'b0;
            cmd_q <= '0;
        end else begin
            if (reg_we) ie_q <= reg_wdata[CB_IE];
            if (arm) begin
                en_q  <= 1'b1;
                cmd_q <= reg_wdata[CB_SIG:CB_ERASE];
            end else if (expire || imm_done || finish) begin
                en_q  <= 1'b0;
                cmd_q <= '0;
            end
        end
    end

    // Lock bits: programming can only clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n)              lock_q <= 8'hFF;
        else if (op == OP_LOCK)  lock_q <= lock_q & r0_data;
    end

    // Latch the kind and page of the running backend operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            page_q <= '0;
        end else if (start) begin
            wr_q   <= (op == OP_WRITE);
            page_q <= page;
        end
    end

    // Special load data: lock/fuse under lock set, else signature.
    always_comb begin
        ld_special = ld_strobe && ld_open && (cmd_q[2] || cmd_q[4]);
        if (!ld_special)  ld_data = 8'h00;
        else if (cmd_q[2]) ld_data = zptr[0] ? fuse_data : lock_q;
        else              ld_data = sig_data;
    end

    assign reg_rdata  = {ie_q, rww_busy, cmd_q, en_q};
    assign lock_bits  = lock_q;
    assign prog_write = wr_q;
    assign prog_page  = page_q;
    assign irq        = ie_q && gie && !en_q;

    a_r2_expire_clears: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !en_q);
    a_r5_en_held: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> en_q);
    a_r3_special_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ld_special |-> ld_strobe);
    a_r2_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_strobe && ld_strobe));
    a_r11_lock_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOCK) |=> ((lock_bits & ~$past(lock_bits)) == 8'h00));
endmodule

// File: tb/fspm_ctrl_test.sv
module fspm_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int P = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic gie = 1'b1;
    logic st_strobe = 1'b0, ld_strobe = 1'b0;
    logic [15:0] zptr = 16'h0000;
    logic [7:0] r0_data = 8'hFC, sig_data = 8'h1E, fuse_data = 8'h62;
    logic [7:0] reg_rdata, ld_data, lock_bits;
    logic ld_special, rww_busy, prog_busy, prog_write, prog_done;
    logic buf_full, buf_drop, irq;
    logic [8:0] prog_page;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fspm_ctrl #(.PROG_CYCLES(P)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .gie(gie), .st_strobe(st_strobe),
        .ld_strobe(ld_strobe), .zptr(zptr), .r0_data(r0_data),
        .sig_data(sig_data), .fuse_data(fuse_data), .ld_special(ld_special),
        .ld_data(ld_data), .rww_busy(rww_busy), .prog_busy(prog_busy),
        .prog_write(prog_write), .prog_page(prog_page), .prog_done(prog_done),
        .lock_bits(lock_bits), .buf_full(buf_full), .buf_drop(buf_drop),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic store(input int n);
        repeat (n - 1) @(negedge clk);
        st_strobe = 1'b1;
        @(negedge clk);
        st_strobe = 1'b0;
    endtask

    task automatic load(input int n, input logic sp, input logic [7:0] d, input string tag);
        repeat (n - 1) @(negedge clk);
        ld_strobe = 1'b1;
        #1;
        chk({tag, " special"}, ld_special, sp);
        chk({tag, " data"}, ld_data, d);
        @(negedge clk);
        ld_strobe = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            if (prog_done) break;
            @(negedge clk);
        end
        chk("R5 done seen", prog_done, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 lock", lock_bits, 8'hFF);
        chk("R1 idle", {rww_busy, prog_busy, prog_done, buf_full, buf_drop, irq}, 6'b0);
    endtask

    task automatic t_expiry();
        wr(8'h05);
        repeat (3) @(negedge clk);
        chk("R2 still armed", reg_rdata, 8'h05);
        @(negedge clk);
        chk("R2 expired", reg_rdata, 8'h00);
        zptr = 16'h0180;
        wr(8'h03);
        store(5);
        chk("R2 late store busy", prog_busy, 1'b0);
        chk("R2 late store rdata", reg_rdata, 8'h00);
    endtask

    task automatic t_erase();
        zptr = 16'h0180;
        wr(8'h03);
        store(2);
        chk("R6 rww set", rww_busy, 1'b1);
        chk("R5 busy", prog_busy, 1'b1);
        chk("R5 page", prog_page, 9'd3);
        chk("R5 kind", prog_write, 1'b0);
        chk("R5 rdata running", reg_rdata, 8'h43);
        repeat (P - 1) @(negedge clk);
        chk("R5 last busy cycle", {prog_busy, prog_done, reg_rdata}, {2'b10, 8'h43});
        @(negedge clk);
        chk("R5 finished", {prog_busy, prog_done, reg_rdata}, {2'b01, 8'h40});
        @(negedge clk);
        chk("R5 done one cycle", prog_done, 1'b0);
        wr(8'h11);
        chk("R7 rwwre armed", reg_rdata, 8'h51);
        store(1);
        chk("R7 rwwre clears", {rww_busy, reg_rdata}, {1'b0, 8'h00});
    endtask

    task automatic t_priority();
        zptr = 16'h0180;
        wr(8'h07);
        store(1);
        chk("R13 erase wins", {prog_busy, prog_write}, 2'b10);
        chk("R13 rdata", reg_rdata, 8'h47);
        wait_done();
        chk("R5 bits cleared", reg_rdata, 8'h40);
        wr(8'h01);
        store(1);
        chk("R7 fill clears rww", {rww_busy, reg_rdata}, {1'b0, 8'h00});
        chk("R10 fill sets buf", buf_full, 1'b1);
    endtask

    task automatic t_abort();
        wr(8'h10);
        chk("R9 drop pulse", buf_drop, 1'b1);
        chk("R9 buffer empty", buf_full, 1'b0);
        chk("R9 not armed", reg_rdata, 8'h00);
        @(negedge clk);
        chk("R9 drop one cycle", buf_drop, 1'b0);
    endtask

    task automatic t_write();
        wr(8'h01);
        store(1);
        chk("R10 fill again", buf_full, 1'b1);
        zptr = 16'hFA00;
        wr(8'h05);
        store(4);
        chk("R6 high page no rww", rww_busy, 1'b0);
        chk("R5 write kind", {prog_busy, prog_write}, 2'b11);
        chk("R5 write page", prog_page, 9'd500);
        wr(8'h11);
        chk("R8 refused arm", reg_rdata, 8'h05);
        store(1);
        chk("R8 refused rwwre", {rww_busy, reg_rdata}, {1'b0, 8'h05});
        wait_done();
        chk("R10 write empties", buf_full, 1'b0);
        chk("R5 write clears bits", reg_rdata, 8'h00);
    endtask

    task automatic t_sig();
        wr(8'h21);
        load(3, 1'b1, 8'h1E, "R3 sig load");
        @(negedge clk);
        chk("R3 sig expiry", reg_rdata, 8'h00);
        wr(8'h21);
        store(2);
        chk("R4 sig store ignored", {prog_busy, reg_rdata}, {1'b0, 8'h21});
        chk("R4 lock untouched", lock_bits, 8'hFF);
        repeat (2) @(negedge clk);
        chk("R4 sig expires", reg_rdata, 8'h00);
    endtask

    task automatic t_lock();
        zptr = 16'h0000;
        wr(8'h09);
        load(1, 1'b1, 8'hFF, "R3 lock read");
        store(1);
        chk("R11 lock written", lock_bits, 8'hFC);
        chk("R11 bits clear", reg_rdata, 8'h00);
        zptr = 16'h0001;
        wr(8'h09);
        load(1, 1'b1, 8'h62, "R3 fuse read");
        load(3, 1'b0, 8'h00, "R3 late load");
        chk("R3 window gone", reg_rdata, 8'h00);
        load(1, 1'b0, 8'h00, "R3 unarmed load");
    endtask

    task automatic t_irq();
        wr(8'h80);
        chk("R12 irq on", irq, 1'b1);
        chk("R14 ie set", reg_rdata, 8'h80);
        gie = 1'b0; #1;
        chk("R12 gie gates", irq, 1'b0);
        gie = 1'b1;
        wr(8'h81);
        chk("R12 armed no irq", {irq, reg_rdata}, {1'b0, 8'h81});
        store(1);
        chk("R12 irq back", {irq, reg_rdata}, {1'b1, 8'h80});
        wr(8'hC0);
        chk("R14 busy bit read-only", reg_rdata, 8'h80);
        wr(8'h40);
        chk("R14 ie cleared", {irq, reg_rdata}, {1'b0, 8'h00});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_expiry();
        t_erase();
        t_priority();
        t_abort();
        t_write();
        t_sig();
        t_lock();
        t_irq();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule